// File: doc/BRIEF.md
# Gated Period Timer

A free-running up-counter with a programmable terminal value and three clock sources. It can count system clocks, count rising edges seen on one external pin, or count system clocks only while that pin is held high. The last source measures how long the pin stays high. When the count reaches the programmed terminal value, the next count step returns it to zero and raises a one-clock match interrupt. In the gated source, a falling pin raises a separate one-clock gate interrupt and leaves the accumulated count in place, where it can be read.

The external pin is asynchronous to the block. It passes through a chain of synchronizer flops before any edge or level is used. There is no prescaler, no cascading to wider counts and no register bus. The mode, enable and terminal value are plain inputs that the surrounding logic drives directly.

Top module: `gated_period_timer`

## Requirements
- R1: After reset, `count` is 0 and both `match_irq` and `gate_irq` are 0.
- R2: With `mode` = 2'b00 (system clock) and `enable` high, `count` rises by one on every clock.
- R3: With `mode` = 2'b01 (pin edges) and `enable` high, `count` rises by one for each 0-to-1 transition of `ext_pin`. The pin is seen after `SYNC_STAGES` flops. Holding the pin high adds only one step.
- R4: With `mode` = 2'b10 (gated) and `enable` high, `count` rises by one on every clock while the synchronized pin is high. A high window of N clocks adds exactly N.
- R5: A count step taken while `count` equals `period` loads 0 instead of `count`+1. `match_irq` is high for exactly the following clock when `period` is non-zero.
- R6: In gated mode, after a match the count stays at 0 until the synchronized pin has been low. Only a new high window resumes counting.
- R7: In gated mode with `enable` high, a 1-to-0 transition of the synchronized pin raises `gate_irq` for one clock and the count is held. In other modes `gate_irq` stays 0.
- R8: While `enable` is low, `count` holds its value and neither interrupt is raised.
- R9: A new `period` value applies from the next step. A count already above `period` runs up to all-ones and rolls over to 0 without a match interrupt.
- R10: `mode` = 2'b11 is reserved. In that mode `count` holds its value and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external clock or gate pin |
| mode | input | 2 | Clock source: 00 system, 01 pin edges, 10 gated, 11 reserved |
| enable | input | 1 | Counting enable |
| period | input | CNT_W | Terminal value of the count |
| count | output | CNT_W | Current count |
| match_irq | output | 1 | One-clock pulse after a step at the terminal value |
| gate_irq | output | 1 | One-clock pulse on a falling gate in gated mode |

## Verification
The assertions check the following on every cycle:
- `count` only steps by one, returns to zero, or holds.
- A match interrupt always coincides with a zero count and does not repeat on the next cycle unless the terminal value is zero.
- A low enable or the reserved mode freezes the count.
- A gate interrupt arises only in gated mode and leaves the count unchanged.

Only the bench scenarios can show the cumulative results. These are: the exact number of steps produced by a sweep of terminal values and run lengths, one step per pin edge rather than per high clock, the length of a gate window, the lock-out after a match in gated mode, and the roll-over past all-ones after the terminal value is lowered.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      SRC_SYSCLK = 2'b00,
      SRC_EDGES  = 2'b01,
      SRC_GATED  = 2'b10,
      SRC_NONE   = 2'b11
   } tmr_src_e;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise,
   output logic fall
);
   logic prev;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= level;
   end

   assign rise = level & ~prev;
   assign fall = ~level & prev;

   p_edges_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall));
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
   import tmr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       enable,
   input  logic       level,
   input  logic       rise,
   input  logic       fall,
   input  logic       wrap,
   output logic       tick,
   output logic       gate_irq
);
   tmr_src_e src;
   logic     lock;

   assign src = tmr_src_e'(mode);

   always_comb begin
      unique case (src)
         SRC_SYSCLK: tick = enable;
         SRC_EDGES:  tick = enable & rise;
         SRC_GATED:  tick = enable & level & ~lock;
         default:    tick = 1'b0;
      endcase
   end

   // lock-out after a match in gated mode, released by a low gate (R6)
   always_ff @(posedge clk) begin
      if (!rst_n)                          lock <= 1'b0;
      else if (src != SRC_GATED || !level) lock <= 1'b0;
      else if (wrap)                       lock <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) gate_irq <= 1'b0;
      else        gate_irq <= enable && (src == SRC_GATED) && fall;
   end

   p_gate_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      gate_irq |-> ($past(mode) == SRC_GATED));

   p_lock_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && src == SRC_GATED) |-> !tick);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             wrap,
   output logic             match_irq
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   assign wrap = tick && (count == period);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count     <= ZERO;
         match_irq <= 1'b0;
      end else begin
         match_irq <= wrap;
         if (tick) count <= wrap ? ZERO : count + ONE;
      end
   end

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (count == $past(count)) || (count == $past(count) + ONE) || (count == ZERO));

   p_match_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      match_irq |-> (count == ZERO));

   p_match_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      match_irq |=> (!match_irq || $past(period) == ZERO));
endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_pin,
   input  logic [1:0]       mode,
   input  logic             enable,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             match_irq,
   output logic             gate_irq
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("gated_period_timer: CNT_W must lie in 2..32");
   end

   logic pin_s, rise, fall, tick, wrap;

   tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(pin_s));

   tmr_edge u_edge (
      .clk(clk), .rst_n(rst_n), .level(pin_s), .rise(rise), .fall(fall));

   tmr_tick_sel u_sel (
      .clk(clk), .rst_n(rst_n), .mode(mode), .enable(enable),
      .level(pin_s), .rise(rise), .fall(fall), .wrap(wrap),
      .tick(tick), .gate_irq(gate_irq));

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
      .count(count), .wrap(wrap), .match_irq(match_irq));

   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> ($stable(count) && !match_irq && !gate_irq));

   p_gate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      gate_irq |-> $stable(count));

   p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SRC_NONE) |=> ($stable(count) && !match_irq && !gate_irq));
endmodule

// File: tb/sim_gated_period_timer.sv
module sim_gated_period_timer;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ext_pin = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic         enable = 1'b0;
   logic [W-1:0] period = '0;
   logic [W-1:0] count;
   logic         match_irq, gate_irq;

   int checks = 0, fails = 0, n_match = 0, n_gate = 0;

   always #5 clk = ~clk;

   gated_period_timer #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .mode(mode),
      .enable(enable), .period(period), .count(count),
      .match_irq(match_irq), .gate_irq(gate_irq));

   always @(posedge clk) begin
      if (rst_n && match_irq) n_match++;
      if (rst_n && gate_irq)  n_gate++;
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; enable = 1'b0; ext_pin = 1'b0; mode = 2'b00;
      cyc(3);
      rst_n = 1'b1;
      n_match = 0; n_gate = 0;
      cyc(1);
   endtask

   task automatic run_sys(int p, int m);
      do_reset();
      period = W'(p); mode = 2'b00; enable = 1'b1;
      cyc(m);
      enable = 1'b0;
      cyc(3);
      chk($sformatf("R2 count p=%0d m=%0d", p, m), int'(count), m % (p + 1));
      chk($sformatf("R5 matches p=%0d m=%0d", p, m), n_match, m / (p + 1));
   endtask

   task automatic pin_pulses(int k);
      for (int i = 0; i < k; i++) begin
         ext_pin = 1'b1; cyc(2);
         ext_pin = 1'b0; cyc(2);
      end
      cyc(4);
   endtask

   task automatic gate_window(int n);
      ext_pin = 1'b1; cyc(n);
      ext_pin = 1'b0; cyc(5);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      // R1 reset state
      cyc(2);
      chk("R1 count", int'(count), 0);
      chk("R1 match_irq", int'(match_irq), 0);
      chk("R1 gate_irq", int'(gate_irq), 0);

      // R2 / R5 sweep of terminal values and run lengths
      for (int p = 0; p < 6; p++) begin
         run_sys(p, p);
         run_sys(p, p + 1);
         run_sys(p, 2 * p + 3);
         run_sys(p, 3 * (p + 1));
      end

      // R3 pin-edge counting
      for (int k = 1; k <= 7; k += 3) begin
         do_reset();
         period = 8'd200; mode = 2'b01; enable = 1'b1;
         pin_pulses(k);
         chk($sformatf("R3 edges k=%0d", k), int'(count), k);
         ext_pin = 1'b1; cyc(12); ext_pin = 1'b0; cyc(4);
         chk($sformatf("R3 held level k=%0d", k), int'(count), k + 1);
         chk("R7 no gate irq in edge mode", n_gate, 0);
      end

      // R4 / R7 gated accumulation
      for (int n = 1; n <= 9; n += 4) begin
         do_reset();
         period = 8'd200; mode = 2'b10; enable = 1'b1;
         gate_window(n);
         chk($sformatf("R4 window n=%0d", n), int'(count), n);
         chk("R7 one gate irq", n_gate, 1);
         cyc(6);
         chk("R7 count held after fall", int'(count), n);
         gate_window(3);
         chk($sformatf("R4 second window n=%0d", n), int'(count), n + 3);
         chk("R7 second gate irq", n_gate, 2);
      end

      // R6 lock-out after match in gated mode
      do_reset();
      period = 8'd3; mode = 2'b10; enable = 1'b1;
      ext_pin = 1'b1; cyc(12);
      chk("R6 count at zero while gate high", int'(count), 0);
      chk("R6 single match", n_match, 1);
      ext_pin = 1'b0; cyc(4);
      gate_window(2);
      chk("R6 resumes on new window", int'(count), 2);
      chk("R6 no further match", n_match, 1);
      chk("R7 gate irqs", n_gate, 2);

      // R8 enable low freezes everything
      do_reset();
      period = 8'd2; mode = 2'b01;
      pin_pulses(3);
      chk("R8 edges ignored", int'(count), 0);
      mode = 2'b10;
      gate_window(6);
      chk("R8 gate ignored", int'(count), 0);
      chk("R8 no gate irq", n_gate, 0);
      mode = 2'b00; enable = 1'b1; cyc(2); enable = 1'b0; cyc(10);
      chk("R8 count frozen", int'(count), 2);
      chk("R8 no match irq", n_match, 0);

      // R9 period change applies at once
      do_reset();
      period = 8'd10; mode = 2'b00; enable = 1'b1; cyc(2);
      period = 8'd4; cyc(3); enable = 1'b0; cyc(2);
      chk("R9 lowered period wraps", int'(count), 0);
      chk("R9 one match", n_match, 1);
      do_reset();
      period = 8'd10; enable = 1'b1; cyc(6);
      period = 8'd3; cyc(250); enable = 1'b0; cyc(2);
      chk("R9 rollover past all-ones", int'(count), 0);
      chk("R9 no match on rollover", n_match, 0);
      enable = 1'b1; cyc(3); enable = 1'b0; cyc(2);
      chk("R9 counts up after rollover", int'(count), 3);

      // R10 reserved mode
      mode = 2'b11; enable = 1'b1;
      pin_pulses(4);
      gate_window(5);
      enable = 1'b0; cyc(2);
      chk("R10 reserved mode holds", int'(count), 3);
      chk("R10 no irq", n_match + n_gate, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule